// File: doc/BRIEF.md
# Output Driver Enable Qualifier

This block decides when the serial output drivers of a transmitter may switch on after power-up or after the input clock comes back. It counts rising edges of the input clock while a clock-present flag is high. Depending on a 2-bit policy held in a small configuration register, it enables the drivers after a short wait, after a long wait, after a short wait during which a phase-lock flag has stayed high, or as soon as the clock is present.

The policy register is written through a plain write strobe and falls back to the short-wait policy whenever power-down is asserted. Power-down is active low and clears all state asynchronously. When the clock-present flag drops, or the lock flag drops under the lock policy, the enable falls in the same cycle and the wait starts over. When the wait has elapsed, the counter stops at its limit and the enable stays on until one of those events occurs.

Policy encoding: 2'b00 short wait, 2'b01 long wait, 2'b10 short wait with lock, 2'b11 clock presence only. The block has no data stream, so all pins are plain level controls.

Top module: `oe_lock_qualifier`

## Requirements
- R1: While `pwdn_n` is low, `drv_en` is 0. On release, the policy register holds 2'b00 (short wait), whatever was written before.
- R2: Under policy 2'b00, `drv_en` is 0 after SHORT_WAIT-1 (1023) rising edges with `clk_present` high, and 1 after SHORT_WAIT (1024). `pll_locked` has no effect.
- R3: Under policy 2'b01, `drv_en` is 0 after LONG_WAIT-1 (2047) counted edges and 1 after LONG_WAIT (2048).
- R4: Under policy 2'b10, `drv_en` needs SHORT_WAIT consecutive edges with both `clk_present` and `pll_locked` high. While `pll_locked` is low, `drv_en` is 0.
- R5: Under policy 2'b11, `drv_en` equals `clk_present` in the same cycle, with no wait.
- R6: When `clk_present` goes low, `drv_en` drops in the same cycle and the edge count restarts from zero.
- R7: Once the limit is reached, the count saturates and `drv_en` stays at 1 for as long as the qualifying conditions hold.
- R8: Under policy 2'b10, a drop of `pll_locked` after enable clears `drv_en` at once. A full SHORT_WAIT of locked edges is needed again before it returns.
- R9: A write on `cfg_wr` takes effect at the next rising edge. A switch from 2'b00 to 2'b01 after enable drops `drv_en` and resumes counting from the saturated short count up to LONG_WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock being qualified |
| pwdn_n | input | 1 | Active-low power-down; asynchronous clear |
| clk_present | input | 1 | High while the input clock is detected |
| pll_locked | input | 1 | High while the PLL strobes are in phase with the reference |
| cfg_wr | input | 1 | Write strobe for the policy register |
| cfg_mode | input | 2 | Policy value written on `cfg_wr` |
| drv_en | output | 1 | Enable for the serial output drivers |

## Verification
Every policy is tried with a fresh start and a wait of exactly one edge below and exactly at its limit. This separates an off-by-one in the counter from a wrong limit, and separates the short limit from the long one. The lock policy is also run with the lock flag held low and dropped after enable, which shows whether the lock both gates the output and restarts the count. The presence-only policy is sampled with zero wait, and the short policy is run with lock low to show the lock is ignored there. Finally, a policy rewrite after saturation shows that the count carries over rather than restarting.

// File: rtl/oelq_pkg.sv
package oelq_pkg;
  typedef enum logic [1:0] {
    MODE_SHORT   = 2'b00,
    MODE_LONG    = 2'b01,
    MODE_LOCKED  = 2'b10,
    MODE_PRESENT = 2'b11
  } oe_mode_e;
endpackage

// File: rtl/oelq_mode_reg.sv
module oelq_mode_reg
  import oelq_pkg::*;
(
  input  logic       clk,
  input  logic       pwdn_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  output oe_mode_e   mode
);
  always_ff @(posedge clk or negedge pwdn_n) begin
    if (!pwdn_n)  mode <= MODE_SHORT;
    else if (wr)  mode <= oe_mode_e'(wdata);
  end
endmodule

// File: rtl/oelq_cycle_counter.sv
module oelq_cycle_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          pwdn_n,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          reached
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge pwdn_n) begin
    if (!pwdn_n)           cnt <= '0;
    else if (clear)        cnt <= '0;
    else if (cnt < limit)  cnt <= cnt + 1'b1;
  end

  assign reached = (cnt >= limit);
endmodule

// File: rtl/oelq_enable_policy.sv
module oelq_enable_policy
  import oelq_pkg::*;
#(
  parameter int SHORT_WAIT = 1024,
  parameter int LONG_WAIT  = 2048,
  parameter int CW         = 12
) (
  input  oe_mode_e      mode,
  input  logic          pwdn_n,
  input  logic          clk_present,
  input  logic          pll_locked,
  input  logic          reached,
  output logic          clear,
  output logic [CW-1:0] limit,
  output logic          drv_en
);
  logic lock_ok;

  always_comb begin
    lock_ok = (mode != MODE_LOCKED) || pll_locked;
    clear   = !clk_present || !lock_ok;
    limit   = (mode == MODE_LONG) ? CW'(LONG_WAIT) : CW'(SHORT_WAIT);
    drv_en  = pwdn_n && clk_present &&
              ((mode == MODE_PRESENT) || (reached && lock_ok));
  end
endmodule

// File: rtl/oe_lock_qualifier.sv
module oe_lock_qualifier
  import oelq_pkg::*;
#(
  parameter int SHORT_WAIT = 1024,
  parameter int LONG_WAIT  = 2048
) (
  input  logic       clk,
  input  logic       pwdn_n,
  input  logic       clk_present,
  input  logic       pll_locked,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_mode,
  output logic       drv_en
);
  localparam int WAIT_MAX = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
  localparam int CW       = $clog2(WAIT_MAX + 1);

  oe_mode_e      mode_q;
  logic          cnt_clear;
  logic          cnt_reached;
  logic [CW-1:0] cnt_limit;

  oelq_mode_reg u_mode (
    .clk   (clk),
    .pwdn_n(pwdn_n),
    .wr    (cfg_wr),
    .wdata (cfg_mode),
    .mode  (mode_q)
  );

  oelq_cycle_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .pwdn_n (pwdn_n),
    .clear  (cnt_clear),
    .limit  (cnt_limit),
    .reached(cnt_reached)
  );

  oelq_enable_policy #(
    .SHORT_WAIT(SHORT_WAIT),
    .LONG_WAIT (LONG_WAIT),
    .CW        (CW)
  ) u_pol (
    .mode       (mode_q),
    .pwdn_n     (pwdn_n),
    .clk_present(clk_present),
    .pll_locked (pll_locked),
    .reached    (cnt_reached),
    .clear      (cnt_clear),
    .limit      (cnt_limit),
    .drv_en     (drv_en)
  );
endmodule

// File: rtl/oe_lock_qualifier_chk.sv
module oe_lock_qualifier_chk (
  input logic       clk,
  input logic       pwdn_n,
  input logic       clk_present,
  input logic       pll_locked,
  input logic       cfg_wr,
  input logic [1:0] mode_q,
  input logic       drv_en
);
  always @(negedge clk) begin
    if (!pwdn_n) AST_PWDN_OFF: assert (!drv_en); // R1
  end

  AST_RESET_MODE: assert property (@(posedge clk) disable iff (!pwdn_n)
    $rose(pwdn_n) |-> (mode_q == 2'b00)); // R1

  AST_NO_EARLY_RISE: assert property (@(posedge clk) disable iff (!pwdn_n)
    ($rose(drv_en) && mode_q != 2'b11) |-> $past(clk_present)); // R2

  AST_LOCK_GATE: assert property (@(posedge clk) disable iff (!pwdn_n)
    (mode_q == 2'b10 && !pll_locked) |-> !drv_en); // R4

  AST_PRESENCE_ONLY: assert property (@(posedge clk) disable iff (!pwdn_n)
    (mode_q == 2'b11) |-> (drv_en == clk_present)); // R5

  AST_NO_CLOCK_OFF: assert property (@(posedge clk) disable iff (!pwdn_n)
    !clk_present |-> !drv_en); // R6

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!pwdn_n)
    (drv_en && !cfg_wr) |=>
      (drv_en || !clk_present || (mode_q == 2'b10 && !pll_locked))); // R7
endmodule

bind oe_lock_qualifier oe_lock_qualifier_chk u_chk (
  .clk        (clk),
  .pwdn_n     (pwdn_n),
  .clk_present(clk_present),
  .pll_locked (pll_locked),
  .cfg_wr     (cfg_wr),
  .mode_q     (mode_q),
  .drv_en     (drv_en)
);

// File: tb/oe_lock_qualifier_bench.sv
`timescale 1ns/1ps
module oe_lock_qualifier_bench;
  logic       clk = 1'b0;
  logic       pwdn_n = 1'b0;
  logic       clk_present = 1'b0;
  logic       pll_locked = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       drv_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  oe_lock_qualifier u_oe_lock_qualifier (
    .clk        (clk),
    .pwdn_n     (pwdn_n),
    .clk_present(clk_present),
    .pll_locked (pll_locked),
    .cfg_wr     (cfg_wr),
    .cfg_mode   (cfg_mode),
    .drv_en     (drv_en)
  );

  // {mode[1:0], lock, expected, edges[11:0]}
  localparam logic [15:0] VECS [0:9] = '{
    {2'b00, 1'b1, 1'b0, 12'd1023},
    {2'b00, 1'b1, 1'b1, 12'd1024},
    {2'b00, 1'b0, 1'b1, 12'd1024},
    {2'b01, 1'b1, 1'b0, 12'd2047},
    {2'b01, 1'b1, 1'b1, 12'd2048},
    {2'b10, 1'b1, 1'b0, 12'd1023},
    {2'b10, 1'b1, 1'b1, 12'd1024},
    {2'b10, 1'b0, 1'b0, 12'd1500},
    {2'b11, 1'b0, 1'b1, 12'd0},
    {2'b11, 1'b1, 1'b1, 12'd5}
  };

  task automatic check(input string req, input logic exp);
    checks++;
    if (drv_en !== exp) begin
      errors++;
      $display("FAIL %s: drv_en=%0b expected %0b at %0t", req, drv_en, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic restart(input logic [1:0] m, input logic lk);
    @(negedge clk);
    pwdn_n = 1'b0; clk_present = 1'b0; cfg_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    pwdn_n = 1'b1; cfg_wr = 1'b1; cfg_mode = m; pll_locked = lk;
    @(negedge clk);
    cfg_wr = 1'b0; clk_present = 1'b1;
  endtask

  function automatic string tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    clk_present = 1'b1;
    edges(3);
    check("R1", 1'b0);

    for (int v = 0; v < 10; v++) begin
      restart(VECS[v][15:14], VECS[v][13]);
      edges(int'(VECS[v][11:0]));
      check(tag(VECS[v][15:14]), VECS[v][12]);
    end

    // R1: policy returns to short wait after power-down
    restart(2'b11, 1'b1);
    @(negedge clk);
    pwdn_n = 1'b0;
    #1 check("R1", 1'b0);
    @(negedge clk);
    pwdn_n = 1'b1;
    edges(1023);
    check("R1", 1'b0);
    edges(1);
    check("R1", 1'b1);

    // R6: clock loss drops at once and restarts the count
    @(negedge clk);
    clk_present = 1'b0;
    #1 check("R6", 1'b0);
    @(negedge clk);
    clk_present = 1'b1;
    edges(1023);
    check("R6", 1'b0);
    edges(1);
    check("R6", 1'b1);

    // R7: saturation keeps the enable on
    edges(3000);
    check("R7", 1'b1);

    // R9: switch to long wait after saturation
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mode = 2'b01;
    #1 check("R9", 1'b1);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1 check("R9", 1'b0);
    edges(1023);
    check("R9", 1'b0);
    edges(1);
    check("R9", 1'b1);

    // R8: lock loss under lock policy
    restart(2'b10, 1'b1);
    edges(1024);
    check("R8", 1'b1);
    @(negedge clk);
    pll_locked = 1'b0;
    #1 check("R8", 1'b0);
    @(negedge clk);
    pll_locked = 1'b1;
    edges(1023);
    check("R8", 1'b0);
    edges(1);
    check("R8", 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule